// File: doc/BRIEF.md
# Block-Ack Window Tracker

This block follows the transmit status of the frames queued for one receiver and traffic class. It runs in one of two modes. In window mode it keeps a "sent" flag, an "acknowledged" flag and a "retransmit pending" flag for every sequence slot in a sliding window of up to 64 frames. Each incoming block-ack bitmap sets acknowledgements and marks holes for retransmission. The window start then moves forward over every acknowledged frame at its head, and the block reports one completion for each frame it passes.

In in-order mode the block ignores bitmaps. The frame at the window start is the only frame in flight. A single acknowledgement completes it. A negative acknowledgement asks for that same frame to be sent again, until a configurable retry limit is used up. The frame then completes with a failure status and the next frame becomes the head. A command queue must be set to in-order mode. The mode, window size and retry limit are static settings: change them only while no event is in flight.

Top module: `ba_window_tracker`

## Requirements
- R1: During and after reset, `win_start` is 0 and `cmp_valid` and `rtx_valid` are 0.
- R2: A frame-sent event is recorded only if `(tx_seq - win_start) mod 4096` is below the effective window size. Otherwise it is ignored, and a later acknowledgement of that sequence number has no effect.
- R3: The effective window size is `cfg_win_size`, with 0 treated as 1 and any value above 64 treated as 64.
- R4: In window mode, bitmap bit i refers to sequence `(ba_ssn + i) mod 4096`, so the start may lie behind the window start. A set bit acknowledges that frame only if it is inside the window and recorded as sent. Bits that map outside the window, or to unsent slots, are ignored.
- R5: In window mode, a clear bitmap bit for a sent, unacknowledged, in-window frame raises a retransmit request. Requests come out one per cycle, lowest offset from `win_start` first, starting one cycle after the bitmap is accepted.
- R6: In window mode, while the frame at `win_start` is sent and acknowledged, the block emits one completion per cycle with `cmp_ok`=1 and `cmp_seq` equal to the old start, and `win_start` steps by one. The first completion appears two clock edges after the bitmap that acknowledged the head.
- R7: `win_start` counts modulo 4096 and wraps from 4095 to 0.
- R8: In in-order mode, bitmaps are ignored. An `ack_valid` with `ack_ok`=1 completes the sent head frame with `cmp_ok`=1 at the very next edge, and `win_start` steps by one.
- R9: In in-order mode, an `ack_valid` with `ack_ok`=0 on the sent head frame raises `rtx_valid` with `rtx_seq`=`win_start` at the next edge. When the failure count reaches `cfg_retry_limit` (0 treated as 1), the head completes with `cmp_ok`=0 instead, and the count restarts for the next frame.
- R10: In window mode, `ack_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_inorder | input | 1 | 1 = in-order single-retry mode, 0 = window mode |
| cfg_win_size | input | 7 | Window size in frames |
| cfg_retry_limit | input | 7 | Failed attempts before an in-order frame is dropped |
| tx_valid | input | 1 | A frame was sent |
| tx_seq | input | 12 | Sequence number of the sent frame |
| ba_valid | input | 1 | Block-ack received |
| ba_ssn | input | 12 | Sequence number of bitmap bit 0 |
| ba_bitmap | input | 64 | Acknowledgement bitmap |
| ack_valid | input | 1 | Single acknowledgement event for the head frame |
| ack_ok | input | 1 | 1 = acknowledged, 0 = attempt failed |
| win_start | output | 12 | Current window start sequence |
| cmp_valid | output | 1 | Completion strobe |
| cmp_seq | output | 12 | Sequence number of the completed frame |
| cmp_ok | output | 1 | 1 = delivered, 0 = dropped after retries |
| rtx_valid | output | 1 | Retransmit request strobe |
| rtx_seq | output | 12 | Sequence number to resend |

## Verification
Any wrong slot flag eventually shows at `win_start`. A lost acknowledgement stalls the start below the expected value. A spurious "sent" or "acknowledged" flag lets the start run past a hole. A flag left behind from an earlier trip around the sequence space shows up as an extra completion when the window returns to that slot.

The bench compares `win_start`, the cumulative completion count and the retransmit stream a few cycles after each event. It also checks the exact edge of the first completion and of the in-order replies. A stale pending flag shows up as a duplicate or out-of-order retransmit request within a few cycles.

// File: rtl/ba_trk_pkg.sv
// Package: shared types for the block-ack window tracker.
// Assumes nothing beyond IEEE 1800-2017.
package ba_trk_pkg;
    typedef enum logic {
        MODE_WINDOW  = 1'b0,
        MODE_INORDER = 1'b1
    } trk_mode_e;
endpackage

// File: rtl/ba_slot_bank.sv
// Slot bank: sent / acknowledged / retransmit-pending flags, one set per
// sequence slot, indexed by the low sequence bits.
// Assumes SLOTS is a power of two and no wider than half the sequence space.
module ba_slot_bank #(
    parameter int SEQ_W = 12,
    parameter int SLOTS = 64,
    parameter int IDX_W = $clog2(SLOTS),
    parameter int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEQ_W-1:0] start,
    input  logic [CNT_W-1:0] win_eff,
    input  logic             tx_set,
    input  logic [IDX_W-1:0] tx_idx,
    input  logic             ba_apply,
    input  logic [SEQ_W-1:0] ba_ssn,
    input  logic [SLOTS-1:0] ba_bmp,
    input  logic             clr_set,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             rclr_set,
    input  logic [IDX_W-1:0] rclr_idx,
    output logic [SLOTS-1:0] sent_o,
    output logic [SLOTS-1:0] acked_o,
    output logic [SLOTS-1:0] pend_o
);
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        logic             sent_q, acked_q, pend_q;
        logic [IDX_W-1:0] off;
        logic [SEQ_W-1:0] slot_seq, bdist;
        logic             in_win, in_ba, hit, bbit;

        // Purpose: locate this slot relative to the window and the bitmap.
        always_comb begin
            off      = IDX_W'(j) - start[IDX_W-1:0];
            slot_seq = start + SEQ_W'(off);
            bdist    = slot_seq - ba_ssn;
            in_win   = CNT_W'(off) < win_eff;
            in_ba    = bdist < SEQ_W'(SLOTS);
            bbit     = ba_bmp[bdist[IDX_W-1:0]];
            hit      = ba_apply && in_win && in_ba && sent_q;
        end

        // Purpose: update the three flags of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sent_q  <= 1'b0;
                acked_q <= 1'b0;
                pend_q  <= 1'b0;
            end else if (clr_set && clr_idx == IDX_W'(j)) begin
                sent_q  <= 1'b0;
                acked_q <= 1'b0;
                pend_q  <= 1'b0;
            end else if (tx_set && tx_idx == IDX_W'(j)) begin
                sent_q  <= 1'b1;
                acked_q <= 1'b0;
                pend_q  <= 1'b0;
            end else begin
                if (rclr_set && rclr_idx == IDX_W'(j)) pend_q <= 1'b0;
                if (hit) begin
                    if (bbit) begin
                        acked_q <= 1'b1;
                        pend_q  <= 1'b0;
                    end else if (!acked_q) begin
                        pend_q  <= 1'b1;
                    end
                end
            end
        end

        assign sent_o[j]  = sent_q;
        assign acked_o[j] = acked_q;
        assign pend_o[j]  = pend_q;
    end
endmodule

// File: rtl/ba_rot_pick.sv
// Rotating picker: finds the set mask bit with the smallest offset from base.
// Assumes SLOTS is a power of two so index arithmetic wraps by itself.
module ba_rot_pick #(
    parameter int SLOTS = 64,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] mask,
    input  logic [IDX_W-1:0] base,
    output logic             found,
    output logic [IDX_W-1:0] off
);
    // Purpose: scan from the far end down so the nearest offset wins.
    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (mask[base + IDX_W'(i)]) begin
                found = 1'b1;
                off   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ba_retry_ctr.sv
// Retry counter for in-order mode: counts failed attempts on the head frame
// and flags the attempt that exhausts the limit (limit 0 acts as 1).
module ba_retry_ctr #(
    parameter int RETRY_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fail_evt,
    input  logic               clear_evt,
    input  logic [RETRY_W-1:0] limit,
    output logic               give_up
);
    logic [RETRY_W-1:0] cnt_q;
    logic [RETRY_W-1:0] lim_eff;
    logic [RETRY_W:0]   cnt_next;

    // Purpose: compare the incremented count against the effective limit.
    always_comb begin
        lim_eff  = (limit == '0) ? RETRY_W'(1) : limit;
        cnt_next = {1'b0, cnt_q} + 1'b1;
        give_up  = fail_evt && (cnt_next >= {1'b0, lim_eff});
    end

    // Purpose: hold the failure count of the current head frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_evt || give_up) cnt_q <= '0;
        else if (fail_evt)                  cnt_q <= cnt_next[RETRY_W-1:0];
    end
endmodule

// File: rtl/ba_window_tracker.sv
// Top: block-ack window tracker for one receiver/traffic-class queue.
// Window mode: bitmap-driven acknowledgement, hole retransmission, head
// advance one slot per cycle. In-order mode: single head frame with retries.
// Assumes the configuration inputs change only while idle.
module ba_window_tracker #(
    parameter int SEQ_W   = 12,
    parameter int WIN_MAX = 64,
    parameter int CFG_W   = 7,
    parameter int RETRY_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_inorder,
    input  logic [CFG_W-1:0]   cfg_win_size,
    input  logic [RETRY_W-1:0] cfg_retry_limit,
    input  logic               tx_valid,
    input  logic [SEQ_W-1:0]   tx_seq,
    input  logic               ba_valid,
    input  logic [SEQ_W-1:0]   ba_ssn,
    input  logic [WIN_MAX-1:0] ba_bitmap,
    input  logic               ack_valid,
    input  logic               ack_ok,
    output logic [SEQ_W-1:0]   win_start,
    output logic               cmp_valid,
    output logic [SEQ_W-1:0]   cmp_seq,
    output logic               cmp_ok,
    output logic               rtx_valid,
    output logic [SEQ_W-1:0]   rtx_seq
);
    import ba_trk_pkg::*;

    localparam int IDX_W = $clog2(WIN_MAX);
    localparam int CNT_W = IDX_W + 1;

    trk_mode_e          mode;
    logic [CNT_W-1:0]   win_eff;
    logic [SEQ_W-1:0]   tx_off;
    logic               tx_acc;
    logic [IDX_W-1:0]   s_idx;
    logic [WIN_MAX-1:0] sent, acked, pend;
    logic               win_adv, io_ack, io_ok, io_fail, give_up, advance;
    logic               pick_found, rtx_w;
    logic [IDX_W-1:0]   pick_off;

    // Purpose: decode mode, clamp the window and qualify frame-sent events.
    always_comb begin
        mode = trk_mode_e'(cfg_inorder);
        if (cfg_win_size == '0)               win_eff = CNT_W'(1);
        else if (int'(cfg_win_size) > WIN_MAX) win_eff = CNT_W'(WIN_MAX);
        else                                   win_eff = CNT_W'(cfg_win_size);
        tx_off = tx_seq - win_start;
        tx_acc = tx_valid && (tx_off < SEQ_W'(win_eff));
        s_idx  = win_start[IDX_W-1:0];
    end

    // Purpose: decide head advance, in-order outcome and retransmit choice.
    always_comb begin
        win_adv = (mode == MODE_WINDOW) && sent[s_idx] && acked[s_idx];
        io_ack  = (mode == MODE_INORDER) && ack_valid && sent[s_idx];
        io_ok   = io_ack && ack_ok;
        io_fail = io_ack && !ack_ok;
        advance = win_adv || io_ok || give_up;
        rtx_w   = (mode == MODE_WINDOW) && pick_found;
    end

    ba_slot_bank #(
        .SEQ_W(SEQ_W), .SLOTS(WIN_MAX), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (win_start),
        .win_eff  (win_eff),
        .tx_set   (tx_acc),
        .tx_idx   (tx_seq[IDX_W-1:0]),
        .ba_apply (ba_valid && (mode == MODE_WINDOW)),
        .ba_ssn   (ba_ssn),
        .ba_bmp   (ba_bitmap),
        .clr_set  (advance),
        .clr_idx  (s_idx),
        .rclr_set (rtx_w),
        .rclr_idx (s_idx + pick_off),
        .sent_o   (sent),
        .acked_o  (acked),
        .pend_o   (pend)
    );

    ba_rot_pick #(.SLOTS(WIN_MAX), .IDX_W(IDX_W)) u_pick (
        .mask  (pend),
        .base  (s_idx),
        .found (pick_found),
        .off   (pick_off)
    );

    ba_retry_ctr #(.RETRY_W(RETRY_W)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_evt  (io_fail),
        .clear_evt (io_ok || (mode == MODE_WINDOW)),
        .limit     (cfg_retry_limit),
        .give_up   (give_up)
    );

    // Purpose: register the window start, completion and retransmit outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_start <= '0;
            cmp_valid <= 1'b0;
            cmp_seq   <= '0;
            cmp_ok    <= 1'b0;
            rtx_valid <= 1'b0;
            rtx_seq   <= '0;
        end else begin
            cmp_valid <= advance;
            cmp_seq   <= win_start;
            cmp_ok    <= win_adv || io_ok;
            if (advance) win_start <= win_start + 1'b1;
            rtx_valid <= rtx_w || (io_fail && !give_up);
            rtx_seq   <= rtx_w ? win_start + SEQ_W'(pick_off) : win_start;
        end
    end
endmodule

// File: rtl/ba_window_tracker_chk.sv
// Checker: port-level properties of the window tracker, bound to the top.
module ba_window_tracker_chk #(
    parameter int SEQ_W   = 12,
    parameter int WIN_MAX = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_inorder,
    input logic [SEQ_W-1:0] win_start,
    input logic             cmp_valid,
    input logic [SEQ_W-1:0] cmp_seq,
    input logic             cmp_ok,
    input logic             rtx_valid,
    input logic [SEQ_W-1:0] rtx_seq
);
    AST_CMP_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (win_start == SEQ_W'(cmp_seq + 1'b1))); // R6
    AST_START_ONLY_ON_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(win_start) |-> cmp_valid); // R6
    AST_WINDOW_CMP_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_inorder && cmp_valid) |-> cmp_ok); // R6
    AST_INORDER_RTX_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_inorder && rtx_valid) |-> (rtx_seq == win_start)); // R9
    AST_RTX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rtx_valid |-> (SEQ_W'(rtx_seq - win_start) < SEQ_W'(WIN_MAX))); // R5
endmodule

bind ba_window_tracker ba_window_tracker_chk #(
    .SEQ_W(SEQ_W), .WIN_MAX(WIN_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_inorder (cfg_inorder),
    .win_start   (win_start),
    .cmp_valid   (cmp_valid),
    .cmp_seq     (cmp_seq),
    .cmp_ok      (cmp_ok),
    .rtx_valid   (rtx_valid),
    .rtx_seq     (rtx_seq)
);

// File: tb/ba_window_tracker_tb.sv
// Bench: vector table in window mode, then directed tests for reset,
// latency, in-order mode, window clamping and sequence wrap.
module ba_window_tracker_tb;
    localparam logic [2:0] OP_TX = 3'd1;
    localparam logic [2:0] OP_BA = 3'd2;

    typedef struct packed {
        logic [2:0]  op;
        logic [11:0] val;
        logic [63:0] bmp;
        logic [11:0] st;
        logic [15:0] ncmp;
        logic [15:0] nrtx;
        logic [11:0] lrtx;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{OP_TX, 12'd0,    64'h0,     12'd0,  16'd0,  16'd0, 12'd0},
        '{OP_TX, 12'd1,    64'h0,     12'd0,  16'd0,  16'd0, 12'd0},
        '{OP_TX, 12'd2,    64'h0,     12'd0,  16'd0,  16'd0, 12'd0},
        '{OP_TX, 12'd3,    64'h0,     12'd0,  16'd0,  16'd0, 12'd0},
        '{OP_BA, 12'd0,    64'hA,     12'd0,  16'd0,  16'd2, 12'd2},
        '{OP_TX, 12'd0,    64'h0,     12'd0,  16'd0,  16'd2, 12'd2},
        '{OP_TX, 12'd2,    64'h0,     12'd0,  16'd0,  16'd2, 12'd2},
        '{OP_BA, 12'd0,    64'h5,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_TX, 12'd9,    64'h0,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_BA, 12'd9,    64'h1,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_TX, 12'd12,   64'h0,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_BA, 12'd4,    64'h1FF,   12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_TX, 12'd4,    64'h0,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_TX, 12'd5,    64'h0,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_TX, 12'd6,    64'h0,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_TX, 12'd7,    64'h0,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_TX, 12'd8,    64'h0,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_TX, 12'd10,   64'h0,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_TX, 12'd11,   64'h0,     12'd4,  16'd4,  16'd2, 12'd2},
        '{OP_BA, 12'd4,    64'hFF,    12'd12, 16'd12, 16'd2, 12'd2},
        '{OP_BA, 12'd12,   64'h1,     12'd12, 16'd12, 16'd2, 12'd2},
        '{OP_TX, 12'd12,   64'h0,     12'd12, 16'd12, 16'd2, 12'd2},
        '{OP_TX, 12'd13,   64'h0,     12'd12, 16'd12, 16'd2, 12'd2},
        '{OP_BA, 12'd4090, 64'hC0000, 12'd14, 16'd14, 16'd2, 12'd2},
        '{OP_TX, 12'd14,   64'h0,     12'd14, 16'd14, 16'd2, 12'd2},
        '{OP_BA, 12'd14,   64'h0,     12'd14, 16'd14, 16'd3, 12'd14}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_inorder = 1'b0;
    logic [6:0]  cfg_win_size = 7'd8;
    logic [6:0]  cfg_retry_limit = 7'd3;
    logic        tx_valid = 1'b0;
    logic [11:0] tx_seq = '0;
    logic        ba_valid = 1'b0;
    logic [11:0] ba_ssn = '0;
    logic [63:0] ba_bitmap = '0;
    logic        ack_valid = 1'b0;
    logic        ack_ok = 1'b0;
    logic [11:0] win_start, cmp_seq, rtx_seq;
    logic        cmp_valid, cmp_ok, rtx_valid;

    int checks = 0;
    int errors = 0;
    int cmp_n = 0;
    int fail_n = 0;
    int rtx_n = 0;
    logic [11:0] last_rtx = '0;

    always #4 clk = ~clk;

    ba_window_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_inorder(cfg_inorder),
        .cfg_win_size(cfg_win_size), .cfg_retry_limit(cfg_retry_limit),
        .tx_valid(tx_valid), .tx_seq(tx_seq), .ba_valid(ba_valid),
        .ba_ssn(ba_ssn), .ba_bitmap(ba_bitmap), .ack_valid(ack_valid),
        .ack_ok(ack_ok), .win_start(win_start), .cmp_valid(cmp_valid),
        .cmp_seq(cmp_seq), .cmp_ok(cmp_ok), .rtx_valid(rtx_valid),
        .rtx_seq(rtx_seq)
    );

    // Event monitor: counts completions and retransmit requests.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmp_valid) begin
                cmp_n++;
                if (!cmp_ok) fail_n++;
            end
            if (rtx_valid) begin
                rtx_n++;
                last_rtx = rtx_seq;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Each op is driven for one edge; returns at the negedge after that edge.
    task automatic do_tx(input logic [11:0] s);
        tx_valid = 1'b1; tx_seq = s;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic do_ba(input logic [11:0] s, input logic [63:0] b);
        ba_valid = 1'b1; ba_ssn = s; ba_bitmap = b;
        @(negedge clk);
        ba_valid = 1'b0;
    endtask

    task automatic do_ack(input logic ok);
        ack_valid = 1'b1; ack_ok = ok;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cmp0;
        int rtx0;
        idle(3);
        check("R1 start in reset", win_start, 0);
        check("R1 cmp in reset", cmp_valid, 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 start after reset", win_start, 0);
        check("R1 rtx after reset", rtx_valid, 0);

        // Vector table, window mode, window size 8 (R2 R4 R5 R6 R7).
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op == OP_TX) do_tx(VECS[i].val);
            else                     do_ba(VECS[i].val, VECS[i].bmp);
            idle(12);
            check("R6 vec start", win_start, VECS[i].st);
            check("R4 vec completions", cmp_n, VECS[i].ncmp);
            check("R5 vec retransmits", rtx_n, VECS[i].nrtx);
            check("R5 vec last retransmit", last_rtx, VECS[i].lrtx);
        end

        // R6 exact latency of the first completion.
        do_ba(12'd14, 64'h1);
        check("R6 no completion one edge after bitmap", cmp_valid, 0);
        check("R6 start unchanged one edge after bitmap", win_start, 14);
        @(negedge clk);
        check("R6 completion valid", cmp_valid, 1);
        check("R6 completion seq", cmp_seq, 14);
        check("R6 completion ok", cmp_ok, 1);
        check("R6 start stepped", win_start, 15);

        // R10 single ack ignored in window mode.
        do_tx(12'd15);
        do_ack(1'b1);
        idle(6);
        check("R10 start unchanged", win_start, 15);
        check("R10 no completion", cmp_n, 15);
        do_ba(12'd15, 64'h1);
        idle(4);
        check("R6 cleanup start", win_start, 16);

        // In-order mode, retry limit 3 (R8 R9).
        cfg_inorder = 1'b1;
        cfg_retry_limit = 7'd3;
        idle(2);
        do_tx(12'd16);
        do_tx(12'd17);
        do_ack(1'b0);
        check("R9 first failure retransmit", rtx_valid, 1);
        check("R9 first failure seq", rtx_seq, 16);
        check("R9 first failure no completion", cmp_valid, 0);
        idle(2);
        do_ack(1'b0);
        check("R9 second failure retransmit", rtx_valid, 1);
        idle(2);
        do_ack(1'b0);
        check("R9 limit completion valid", cmp_valid, 1);
        check("R9 limit completion failed", cmp_ok, 0);
        check("R9 limit completion seq", cmp_seq, 16);
        check("R9 limit no retransmit", rtx_valid, 0);
        check("R9 limit start stepped", win_start, 17);
        idle(2);
        do_ack(1'b1);
        check("R8 ok completion valid", cmp_valid, 1);
        check("R8 ok completion status", cmp_ok, 1);
        check("R8 ok completion seq", cmp_seq, 17);
        check("R8 ok start", win_start, 18);
        do_tx(12'd18);
        do_ba(12'd18, 64'h1);
        idle(6);
        check("R8 bitmap ignored start", win_start, 18);
        do_ack(1'b1);
        idle(2);
        check("R8 head completes", win_start, 19);
        do_tx(12'd19);
        rtx0 = rtx_n;
        do_ack(1'b0);
        idle(2);
        do_ack(1'b0);
        idle(2);
        check("R9 counter restarted per frame", rtx_n, rtx0 + 2);
        check("R9 no drop before limit", fail_n, 1);
        do_ack(1'b1);
        idle(2);
        check("R9 frame after retries ok", win_start, 20);
        cfg_retry_limit = 7'd0;
        do_tx(12'd20);
        do_ack(1'b0);
        check("R9 limit zero drops at once", cmp_valid, 1);
        check("R9 limit zero status", cmp_ok, 0);
        idle(2);
        check("R9 limit zero start", win_start, 21);

        // R3 window size 0 acts as 1.
        cfg_inorder = 1'b0;
        cfg_win_size = 7'd0;
        idle(2);
        do_tx(12'd22);
        do_tx(12'd21);
        do_ba(12'd21, 64'h3);
        idle(6);
        check("R3 size zero stops after one", win_start, 22);
        do_ba(12'd22, 64'h1);
        idle(6);
        check("R3 size zero rejected frame", win_start, 22);

        // R3 size above 64 acts as 64; R7 wrap over the full sequence space.
        cfg_win_size = 7'd100;
        cmp0 = cmp_n;
        idle(2);
        do_tx(12'd86);
        for (int r = 0; r < 64; r++) begin
            logic [11:0] base;
            base = win_start;
            for (int k = 0; k < 64; k++) do_tx(base + 12'(k));
            do_ba(base, {64{1'b1}});
            idle(70);
            if (r == 0) begin
                check("R3 clamp to 64 start", win_start, 86);
                do_ba(12'd86, 64'h1);
                idle(4);
                check("R3 frame at offset 64 rejected", win_start, 86);
            end
        end
        check("R7 wrapped start", win_start, 22);
        check("R7 completions over wrap", cmp_n - cmp0, 4096);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule